// File: doc/BRIEF.md
# DDR ADC Capture Channel Packer

This block receives a four-channel ADC stream on a 29-bit parallel bus that changes on both edges of a source-synchronous clock. Each channel's sample is split over the two edges of one clock period: the rising edge carries the upper half and the falling edge carries the lower half. The block joins the halves into whole samples. It then regroups two consecutive clock periods into one word of a clock at half the rate, and spreads that word over eight 16-bit lanes that downstream capture logic reads once per slow cycle.

An 8-bit channel-select code picks the lane content. One channel gives two samples per slow cycle, each repeated over four lanes. Two channels give four samples, each on two lanes. All four channels give eight samples, one per lane. The divided clock is produced in the block and is also driven out. The lanes change only on the edge where that clock rises. The inversion, bit-order, capture-depth and capture-format controls are present as inputs but have no function.

Top module: `ddr_adc_packer`

## Requirements
- R1: Channel n (n = 0..3) uses bus bits [7n+6:7n], and bit 28 is unused. A sample is 14 bits: {value of that field at the rising edge, value of that field at the next falling edge}.
- R2: `clk_slow` is low while `rst_n` is low. From the first rising edge of `clk_ext` at which `rst_n` is high, it toggles on every rising edge, so it is high after the 1st, 3rd, 5th… edges.
- R3: A lane holds {sample[13:0], 2'b00}: its two low bits are always zero.
- R4: Codes 0, 2, 4 and 8 select channel 0, 1, 2 and 3 alone. Lanes 0–3 carry that channel's older sample and lanes 4–7 carry its newer sample.
- R5: Codes 3 and 12 select the channel pairs {0,1} and {2,3}. Lanes 0–1 carry the lower channel's older sample and lanes 2–3 carry the higher channel's older sample. Lanes 4–5 and 6–7 carry the same two channels' newer samples.
- R6: Code 15 selects all four channels. Lane i carries channel (i mod 4), from the older period for i < 4 and from the newer period for i ≥ 4.
- R7: The older and newer samples of one load come from two consecutive `clk_ext` periods. The older one is placed in the lower lanes.
- R8: Any code other than 0, 2, 3, 4, 8, 12 or 15 loads zero into all eight lanes.
- R9: The lanes change only on `clk_ext` edges where `clk_slow` rises, and they hold their value between such edges. `chan_sel` is sampled on the loading edge.
- R10: Reset is synchronous and active low, and holds all lanes at zero. After release the lanes stay zero through the first two rising edges of `clk_slow`. The first load happens on the fifth `clk_ext` edge after release and uses the periods that began at the 2nd and 3rd edges.
- R11: `rsv_inv_data`, `rsv_inv_clk`, `rsv_lsb_first`, `rsv_depth` and `rsv_format` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ext | input | 1 | Source-synchronous ADC clock; data is taken on both edges |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 29 | DDR data bus, four 7-bit channel fields |
| chan_sel | input | 8 | Channel-select code |
| rsv_inv_data | input | 1 | Reserved, ignored |
| rsv_inv_clk | input | 1 | Reserved, ignored |
| rsv_lsb_first | input | 1 | Reserved, ignored |
| rsv_depth | input | 2 | Reserved, ignored |
| rsv_format | input | 3 | Reserved, ignored |
| clk_slow | output | 1 | Divided clock at half the `clk_ext` rate |
| lanes_o | output | 128 | Eight 16-bit lanes; lane i at bits [16i+15:16i] |

## Verification
The assertions check on every cycle that:
- the divided clock alternates;
- the rising-edge half of each captured sample equals the bus two edges earlier;
- the lanes hold between loads and change only while the divided clock is high;
- the pad bits stay zero;
- unsupported codes clear the lanes;
- one-channel and four-channel loads place the expected sample.

Only the bench's scenarios show the following:
- the exact lane placement for every code, including mid-run code changes;
- the pairing of consecutive periods;
- the five-edge start-up after reset;
- that random activity on the reserved inputs leaves the lanes unchanged.

// File: rtl/adcpk_pkg.sv
// Shared types for the DDR ADC packer: packing mode and channel-select decode.
// Assumes exactly four ADC channels and eight output lanes.
package adcpk_pkg;

    localparam int NUM_CH    = 4;
    localparam int CH_IDX_W  = 2;
    localparam int NUM_LANES = 8;

    typedef enum logic [1:0] {
        PK_NONE = 2'd0,
        PK_ONE  = 2'd1,
        PK_TWO  = 2'd2,
        PK_FOUR = 2'd3
    } pack_mode_e;

    typedef struct packed {
        pack_mode_e          mode;
        logic [CH_IDX_W-1:0] base;
    } pack_sel_t;

    // Map a channel-select code to a packing mode and its first channel.
    function automatic pack_sel_t decode_sel(input logic [7:0] code);
        pack_sel_t r;
        r.mode = PK_NONE;
        r.base = '0;
        case (code)
            8'd0:    begin r.mode = PK_ONE;  r.base = 2'd0; end
            8'd2:    begin r.mode = PK_ONE;  r.base = 2'd1; end
            8'd4:    begin r.mode = PK_ONE;  r.base = 2'd2; end
            8'd8:    begin r.mode = PK_ONE;  r.base = 2'd3; end
            8'd3:    begin r.mode = PK_TWO;  r.base = 2'd0; end
            8'd12:   begin r.mode = PK_TWO;  r.base = 2'd2; end
            8'd15:   begin r.mode = PK_FOUR; r.base = 2'd0; end
            default: begin r.mode = PK_NONE; r.base = 2'd0; end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/adcpk_ddr_capture.sv
// DDR capture: registers the bus on the rising and on the falling edge of
// clk_ext, joins each channel's two halves into one sample, and keeps the
// last two complete periods (cur_o newest, prev_o one period older).
// Assumes the rising-edge half is the upper part of the sample.
module adcpk_ddr_capture #(
    parameter int BUS_W       = 29,
    parameter int PINS_PER_CH = 7,
    parameter int NUM_CH      = 4,
    localparam int SAMPLE_W   = 2 * PINS_PER_CH,
    localparam int USED_W     = NUM_CH * PINS_PER_CH
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [BUS_W-1:0]                 din,
    output logic [NUM_CH-1:0][SAMPLE_W-1:0]  cur_o,
    output logic [NUM_CH-1:0][SAMPLE_W-1:0]  prev_o
);

    logic [USED_W-1:0]                rise_q;
    logic [USED_W-1:0]                fall_q;
    logic [NUM_CH-1:0][SAMPLE_W-1:0]  joined;

    if (BUS_W > USED_W) begin : g_spare
        logic unused_spare_bits;
        assign unused_spare_bits = ^din[BUS_W-1:USED_W];
    end

    // Take the rising-edge half of every channel.
    always_ff @(posedge clk) begin
        if (!rst_n) rise_q <= '0;
        else        rise_q <= din[USED_W-1:0];
    end

    // Take the falling-edge half of every channel.
    always_ff @(negedge clk) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= din[USED_W-1:0];
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_join
        assign joined[c] = {rise_q[c*PINS_PER_CH +: PINS_PER_CH],
                            fall_q[c*PINS_PER_CH +: PINS_PER_CH]};

        // R1: upper half of the newest sample is the bus two edges back.
        a_r1_rise_half: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(rst_n, 2)) |->
            (cur_o[c][SAMPLE_W-1 -: PINS_PER_CH] ==
             $past(din[c*PINS_PER_CH +: PINS_PER_CH], 2)));
    end

    // Shift complete periods through a two-deep history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_o  <= '0;
            prev_o <= '0;
        end else begin
            cur_o  <= joined;
            prev_o <= cur_o;
        end
    end

endmodule

// File: rtl/adcpk_gear.sv
// 2:1 gearing control: divides clk_ext by two into clk_slow_o and issues a
// one-cycle load strobe on the clk_ext edge where clk_slow_o rises. The
// strobe is withheld for the first WARM_SLOW slow rising edges after reset.
module adcpk_gear #(
    parameter int WARM_SLOW = 2,
    localparam int WCNT_W   = $clog2(WARM_SLOW + 1)
) (
    input  logic clk,
    input  logic rst_n,
    output logic clk_slow_o,
    output logic load_o
);

    logic [WCNT_W-1:0] warm_q;
    logic              warm_done;

    assign warm_done = (warm_q == WCNT_W'(WARM_SLOW));

    // Toggle the divided clock on every rising edge out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_slow_o <= 1'b0;
        else        clk_slow_o <= ~clk_slow_o;
    end

    // Count slow rising edges after reset until warm-up completes.
    always_ff @(posedge clk) begin
        if (!rst_n)                         warm_q <= '0;
        else if (!clk_slow_o && !warm_done) warm_q <= warm_q + 1'b1;
    end

    assign load_o = !clk_slow_o && warm_done;

    // R2: the divided clock alternates on every edge out of reset.
    a_r2_slow_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (clk_slow_o != $past(clk_slow_o)));

endmodule

// File: rtl/adcpk_lane_packer.sv
// Lane packer: decodes the channel-select code, picks one sample per lane
// from the older or newer period, left-justifies it with zero padding, and
// registers all lanes on the load strobe. Assumes eight lanes, four channels.
module adcpk_lane_packer
    import adcpk_pkg::*;
#(
    parameter int SAMPLE_W   = 14,
    parameter int LANE_W     = 16,
    localparam int PAD_W     = LANE_W - SAMPLE_W,
    localparam int HALF      = NUM_LANES / 2,
    localparam int LANES_W   = NUM_LANES * LANE_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             load,
    input  logic [7:0]                       chan_sel,
    input  logic [NUM_CH-1:0][SAMPLE_W-1:0]  s_old,
    input  logic [NUM_CH-1:0][SAMPLE_W-1:0]  s_new,
    output logic [LANES_W-1:0]               lanes_q
);

    pack_sel_t          dec;
    logic [LANES_W-1:0] lanes_d;

    assign dec = decode_sel(chan_sel);

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        localparam int USE_NEW  = i / HALF;
        localparam int POS      = i % HALF;
        localparam int TWO_OFF  = POS / (HALF / 2);
        localparam int FOUR_OFF = POS / (HALF / 4);

        logic [CH_IDX_W-1:0] ch;
        logic [SAMPLE_W-1:0] smp;
        logic [LANE_W-1:0]   lane;

        // Choose the channel feeding this lane for the current mode.
        always_comb begin
            case (dec.mode)
                PK_ONE:  ch = dec.base;
                PK_TWO:  ch = dec.base + CH_IDX_W'(TWO_OFF);
                PK_FOUR: ch = CH_IDX_W'(FOUR_OFF);
                default: ch = '0;
            endcase
        end

        // Left-justify the chosen sample; clear the lane for unknown codes.
        always_comb begin
            smp  = (USE_NEW != 0) ? s_new[ch] : s_old[ch];
            lane = '0;
            if (dec.mode != PK_NONE) lane[LANE_W-1 -: SAMPLE_W] = smp;
        end

        assign lanes_d[i*LANE_W +: LANE_W] = lane;

        if (PAD_W > 0) begin : g_pad_chk
            // R3: padding bits of every lane stay zero.
            a_r3_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
                load |=> (lanes_q[i*LANE_W +: PAD_W] == '0));
        end
    end

    // Register the lanes once per slow cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    lanes_q <= '0;
        else if (load) lanes_q <= lanes_d;
    end

    // R9: lanes hold whenever no load is issued.
    a_r9_hold_between_loads: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(lanes_q));

    // R8: an unsupported code clears every lane.
    a_r8_unknown_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (load && dec.mode == PK_NONE) |=> (lanes_q == '0));

    // R4: one-channel mode repeats the older sample across the low half.
    a_r4_single_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (load && dec.mode == PK_ONE) |=>
        (lanes_q[LANE_W-1 -: SAMPLE_W] == $past(s_old[dec.base]) &&
         lanes_q[(HALF-1)*LANE_W +: LANE_W] == lanes_q[LANE_W-1:0]));

    // R6: four-channel mode puts channel 0's older sample on lane 0.
    a_r6_four_lane0: assert property (@(posedge clk) disable iff (!rst_n)
        (load && dec.mode == PK_FOUR) |=>
        (lanes_q[LANE_W-1 -: SAMPLE_W] == $past(s_old[0])));

endmodule

// File: rtl/ddr_adc_packer.sv
// Top of the DDR ADC capture channel packer: DDR capture, 2:1 gearing into a
// divided clock, and channel-selected packing into eight 16-bit lanes. The
// reserved control inputs are accepted and have no function.
// Assumes din is stable around both edges of clk_ext.
module ddr_adc_packer
    import adcpk_pkg::*;
#(
    parameter int BUS_W       = 29,
    parameter int PINS_PER_CH = 7,
    parameter int LANE_W      = 16,
    parameter int WARM_SLOW   = 2,
    localparam int SAMPLE_W   = 2 * PINS_PER_CH,
    localparam int LANES_W    = NUM_LANES * LANE_W
) (
    input  logic               clk_ext,
    input  logic               rst_n,
    input  logic [BUS_W-1:0]   din,
    input  logic [7:0]         chan_sel,
    input  logic               rsv_inv_data,
    input  logic               rsv_inv_clk,
    input  logic               rsv_lsb_first,
    input  logic [1:0]         rsv_depth,
    input  logic [2:0]         rsv_format,
    output logic               clk_slow,
    output logic [LANES_W-1:0] lanes_o
);

    logic [NUM_CH-1:0][SAMPLE_W-1:0] s_cur;
    logic [NUM_CH-1:0][SAMPLE_W-1:0] s_prev;
    logic                            load;
    logic                            unused_reserved;

    assign unused_reserved = ^{rsv_inv_data, rsv_inv_clk, rsv_lsb_first,
                               rsv_depth, rsv_format};

    adcpk_ddr_capture #(
        .BUS_W       (BUS_W),
        .PINS_PER_CH (PINS_PER_CH),
        .NUM_CH      (NUM_CH)
    ) u_capture (
        .clk    (clk_ext),
        .rst_n  (rst_n),
        .din    (din),
        .cur_o  (s_cur),
        .prev_o (s_prev)
    );

    adcpk_gear #(
        .WARM_SLOW (WARM_SLOW)
    ) u_gear (
        .clk        (clk_ext),
        .rst_n      (rst_n),
        .clk_slow_o (clk_slow),
        .load_o     (load)
    );

    adcpk_lane_packer #(
        .SAMPLE_W (SAMPLE_W),
        .LANE_W   (LANE_W)
    ) u_packer (
        .clk      (clk_ext),
        .rst_n    (rst_n),
        .load     (load),
        .chan_sel (chan_sel),
        .s_old    (s_prev),
        .s_new    (s_cur),
        .lanes_q  (lanes_o)
    );

    // R9: a lane change is only ever seen while the divided clock is high.
    a_r9_change_on_slow_rise: assert property (@(posedge clk_ext) disable iff (!rst_n)
        (lanes_o != $past(lanes_o)) |-> clk_slow);

endmodule

// File: tb/ddr_adc_packer_bench.sv
// Bench: random and directed DDR data with lane values predicted from the
// requirements.
module ddr_adc_packer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int MAXC       = 1024;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [28:0]  din = '0;
    logic [7:0]   chan_sel = '0;
    logic         rsv_inv_data = 1'b0;
    logic         rsv_inv_clk = 1'b0;
    logic         rsv_lsb_first = 1'b0;
    logic [1:0]   rsv_depth = '0;
    logic [2:0]   rsv_format = '0;
    logic         clk_slow;
    logic [127:0] lanes_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddr_adc_packer u_ddr_adc_packer (
        .clk_ext       (clk),
        .rst_n         (rst_n),
        .din           (din),
        .chan_sel      (chan_sel),
        .rsv_inv_data  (rsv_inv_data),
        .rsv_inv_clk   (rsv_inv_clk),
        .rsv_lsb_first (rsv_lsb_first),
        .rsv_depth     (rsv_depth),
        .rsv_format    (rsv_format),
        .clk_slow      (clk_slow),
        .lanes_o       (lanes_o)
    );

    int           tests = 0;
    int           fails = 0;
    int           k = 0;
    int           seed_val;
    bit           rsv_tag = 1'b0;
    logic [28:0]  rv [MAXC];
    logic [28:0]  fv [MAXC];
    logic [7:0]   sv [MAXC];
    logic [127:0] held = '0;
    logic [7:0]   codes [7] = '{8'd0, 8'd2, 8'd4, 8'd8, 8'd3, 8'd12, 8'd15};

    // R1: 14-bit sample of channel c from one period's two halves.
    function automatic logic [13:0] smp(input logic [28:0] r, input logic [28:0] f, input int c);
        return {r[c*7 +: 7], f[c*7 +: 7]};
    endfunction

    // Expected lanes from R3..R8 for one load.
    function automatic logic [127:0] exp_pack(input logic [7:0] sel,
                                              input logic [28:0] ro, input logic [28:0] fo,
                                              input logic [28:0] rn, input logic [28:0] fn);
        int chans [4];
        int n = 0;
        logic [13:0] lst [8];
        logic [127:0] res = '0;
        case (sel)
            8'd0:  begin chans[0] = 0; n = 1; end
            8'd2:  begin chans[0] = 1; n = 1; end
            8'd4:  begin chans[0] = 2; n = 1; end
            8'd8:  begin chans[0] = 3; n = 1; end
            8'd3:  begin chans[0] = 0; chans[1] = 1; n = 2; end
            8'd12: begin chans[0] = 2; chans[1] = 3; n = 2; end
            8'd15: begin for (int j = 0; j < 4; j++) chans[j] = j; n = 4; end
            default: n = 0;
        endcase
        if (n == 0) return '0;
        for (int t = 0; t < 2; t++)
            for (int j = 0; j < n; j++)
                lst[t*n + j] = (t == 0) ? smp(ro, fo, chans[j]) : smp(rn, fn, chans[j]);
        for (int i = 0; i < 8; i++)
            res[i*16 +: 16] = {lst[i / (8 / (2*n))], 2'b00};
        return res;
    endfunction

    function automatic string mode_tag(input logic [7:0] sel);
        case (sel)
            8'd0, 8'd2, 8'd4, 8'd8: return "R4";
            8'd3, 8'd12:            return "R5";
            8'd15:                  return "R6";
            default:                return "R8";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h (k=%0d)", tag, act, exp, k);
        end
    endtask

    // One clk_ext period: drive the rising half, check after the edge, drive the falling half.
    task automatic step(input bit run, input logic [7:0] sel,
                        input logic [28:0] r, input logic [28:0] f);
        logic [127:0] exp;
        string        tag;
        @(negedge clk);
        #2;
        rst_n         = run;
        din           = r;
        chan_sel      = sel;
        rsv_inv_data  = 1'($urandom());
        rsv_inv_clk   = 1'($urandom());
        rsv_lsb_first = 1'($urandom());
        rsv_depth     = 2'($urandom());
        rsv_format    = 3'($urandom());
        if (run) begin rv[k] = r; sv[k] = sel; end
        @(posedge clk);
        #1;
        if (!run) begin
            chk("R10 reset lanes", lanes_o, '0);
            chk("R10 reset clk_slow (R2)", {127'd0, clk_slow}, '0);
            k    = 0;
            held = '0;
        end else begin
            chk("R2 clk_slow phase", {127'd0, clk_slow}, {127'd0, (k % 2 == 0)});
            if (k < 4) begin
                exp = '0;
                tag = "R10 warm-up zero";
            end else if (k % 2 == 1) begin
                exp = held;
                tag = "R9 hold";
            end else begin
                exp = exp_pack(sv[k], rv[k-3], fv[k-3], rv[k-2], fv[k-2]);
                tag = rsv_tag ? "R11 reserved inert" : mode_tag(sv[k]);
                if (sv[k] == 8'd0) begin
                    chk("R1 field/halves", {114'd0, lanes_o[15:2]}, {114'd0, smp(rv[k-3], fv[k-3], 0)});
                    chk("R7 newer period on lane 4", {114'd0, lanes_o[79:66]},
                        {114'd0, smp(rv[k-2], fv[k-2], 0)});
                end
                begin
                    logic [15:0] low = '0;
                    for (int i = 0; i < 8; i++) low[2*i +: 2] = lanes_o[i*16 +: 2];
                    chk("R3 pad bits", {112'd0, low}, '0);
                end
            end
            chk(tag, lanes_o, exp);
            held = exp;
        end
        #1;
        din = f;
        if (run) begin fv[k] = f; k++; end
    endtask

    function automatic logic [28:0] rnd29();
        return 29'($urandom());
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] extra [3];
        extra = '{8'd1, 8'd5, 8'd255};
        seed_val = int'($urandom(32'd20240611));
        // R10: reset state
        repeat (3) step(1'b0, 8'd15, rnd29(), rnd29());
        // R4 R5 R6: each supported code held for a stretch
        foreach (codes[ci]) repeat (12) step(1'b1, codes[ci], rnd29(), rnd29());
        // R8: unsupported codes
        foreach (extra[ei]) repeat (6) step(1'b1, extra[ei], rnd29(), rnd29());
        // Corner data: all ones against all zeros on the two halves
        repeat (4) step(1'b1, 8'd15, 29'h1FFFFFFF, 29'h0);
        repeat (4) step(1'b1, 8'd0, 29'h0, 29'h1FFFFFFF);
        repeat (4) step(1'b1, 8'd12, 29'h0AAAAAAA, 29'h15555555);
        // Random codes, including unsupported values, changing every period
        repeat (300) begin
            logic [7:0] pick;
            pick = ($urandom() % 4 == 0) ? 8'($urandom()) : codes[$urandom() % 7];
            step(1'b1, pick, rnd29(), rnd29());
        end
        // R11: reserved inputs toggled while four-channel data flows
        rsv_tag = 1'b1;
        repeat (40) step(1'b1, 8'd15, rnd29(), rnd29());
        rsv_tag = 1'b0;
        // R10: reset again mid-stream, then restart
        repeat (2) step(1'b0, 8'd3, rnd29(), rnd29());
        repeat (60) step(1'b1, codes[$urandom() % 7], rnd29(), rnd29());
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule